// File: doc/BRIEF.md
# 64-bit Message Mailbox with Interrupt

The mailbox is a small queue of 64-bit messages that a producer and a consumer reach through a plain word-wide register port. A producer writes the low half of a message first, which is only staged, and then writes the high half, which joins the two halves into one 64-bit entry and places it at the tail of the queue. A consumer reads the low half of the oldest entry without disturbing it and then reads the high half, which hands back the upper word and removes the entry.

Two plain status outputs follow the queue state: an interrupt request that stays high while any message waits, and a full indicator. A sticky flag, read at bit 0 of a status word, records that the queue has reached its capacity or refused a message; software clears it by writing a one to that bit. The register port never stalls: it accepts one request every cycle, and every read request is answered exactly one cycle later with a response strobe, so the consumer must be able to take a response each cycle it issues a read.

Byte addresses used by the port: status word at 0x20, message low half at 0x24, message high half at 0x28.

Top module: `msgbox64`

## Requirements
- R1: A write to 0x24 only loads the staging register; the queue, `irq_not_empty` and `mbox_full` do not change.
- R2: A write to 0x28 when the queue is not full appends the entry {write data as bits 63:32, staged word as bits 31:0}; `irq_not_empty` is high the cycle after.
- R3: A read of 0x24 returns bits 31:0 of the oldest entry and removes nothing; with the queue empty it returns zero.
- R4: A read of 0x28 returns bits 63:32 of the oldest entry and removes it; with the queue empty it returns zero and the state is unchanged.
- R5: Entries leave in the order they entered, and the queue holds exactly DEPTH entries.
- R6: `irq_not_empty` is high exactly when at least one entry is stored.
- R7: `mbox_full` is high exactly when DEPTH entries are stored.
- R8: A write to 0x28 while full is dropped: the stored entries are unchanged and `mbox_full` stays high.
- R9: Status bit 0 (address 0x20) becomes 1 when a high-half write brings the queue to DEPTH entries or is dropped because it is full; status bits 31:1 read as zero.
- R10: Writing status with bit 0 set clears the sticky bit; writing it with bit 0 clear has no effect.
- R11: After reset the queue is empty, both outputs are low and the sticky bit is clear.
- R12: Every read request gets `bus_rvalid` high with its data exactly one cycle later, and no other cycle has `bus_rvalid` high; reads of unmapped addresses return zero and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Request strobe, one request per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read response strobe, one cycle after a read request |
| bus_rdata | output | 32 | Read response data |
| irq_not_empty | output | 1 | High while at least one message is stored |
| mbox_full | output | 1 | High while the queue holds DEPTH messages |

## Verification
The bench builds the mailbox with DEPTH set to 4 instead of the default 16, so a random mix of pushes and pops reaches the full state, the refused push and the sticky flag many times, and the read and write pointers wrap around the storage often. The address width stays at its default of 8, which keeps the three mapped offsets and several unmapped ones reachable by the random address choice.

// File: rtl/msgbox_pkg.sv
package msgbox_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned MSG_W  = 2 * WORD_W;

  // byte offsets of the mapped registers
  localparam logic [7:0] OFS_STATUS = 8'h20;
  localparam logic [7:0] OFS_MSG_LO = 8'h24;
  localparam logic [7:0] OFS_MSG_HI = 8'h28;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_STAGE_LO,
    OP_PUSH_HI,
    OP_PEEK_LO,
    OP_POP_HI,
    OP_READ_STATUS,
    OP_CLEAR_STICKY,
    OP_READ_OTHER
  } bus_op_e;

  typedef struct packed {
    logic [WORD_W-1:0] hi;
    logic [WORD_W-1:0] lo;
  } msg_t;

endpackage

// File: rtl/msgbox_decode.sv
module msgbox_decode
  import msgbox_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              req_en,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_bit0,
  output bus_op_e           op
);

  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_LO     = ADDR_W'(OFS_MSG_LO);
  localparam logic [ADDR_W-1:0] A_HI     = ADDR_W'(OFS_MSG_HI);

  logic hit_status, hit_lo, hit_hi;

  assign hit_status = (req_addr == A_STATUS);
  assign hit_lo     = (req_addr == A_LO);
  assign hit_hi     = (req_addr == A_HI);

  always_comb begin
    op = OP_IDLE;
    if (req_en) begin
      if (req_we) begin
        if (hit_lo)                     op = OP_STAGE_LO;
        else if (hit_hi)                op = OP_PUSH_HI;
        else if (hit_status && req_bit0) op = OP_CLEAR_STICKY;
        else                            op = OP_IDLE;
      end else begin
        if (hit_lo)          op = OP_PEEK_LO;
        else if (hit_hi)     op = OP_POP_HI;
        else if (hit_status) op = OP_READ_STATUS;
        else                 op = OP_READ_OTHER;
      end
    end
  end

endmodule

// File: rtl/msgbox_queue.sv
module msgbox_queue #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 64,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CNT_W-1:0] count,
  output logic             is_full,
  output logic             is_empty
);

  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] slot [DEPTH];
  logic [PTR_W-1:0] wr_idx, rd_idx;
  logic             do_push, do_pop;

  assign is_full  = (count == CNT_W'(DEPTH));
  assign is_empty = (count == '0);
  assign do_push  = push && !is_full;
  assign do_pop   = pop && !is_empty;
  assign head     = slot[rd_idx];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  // one register bank per entry, loaded only when the write index points at it
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot[i] <= '0;
      end else if (do_push && (wr_idx == PTR_W'(i))) begin
        slot[i] <= push_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_idx <= '0;
      rd_idx <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_idx <= bump(wr_idx);
      if (do_pop)  rd_idx <= bump(rd_idx);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/msgbox_sticky.sv
module msgbox_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clear_i,
  output logic flag_o
);

  // a set in the same cycle as a clear wins, so no event is lost
  always_ff @(posedge clk) begin
    if (!rst_n)       flag_o <= 1'b0;
    else if (set_i)   flag_o <= 1'b1;
    else if (clear_i) flag_o <= 1'b0;
  end

endmodule

// File: rtl/msgbox64.sv
module msgbox64
  import msgbox_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              bus_rvalid,
  output logic [31:0]       bus_rdata,
  output logic              irq_not_empty,
  output logic              mbox_full
);

  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  bus_op_e           op;
  logic [WORD_W-1:0] stage_q;
  msg_t              push_msg, head_msg;
  logic [CNT_W-1:0]  fill;
  logic              q_full, q_empty;
  logic              sticky_q, sticky_set;
  logic [WORD_W-1:0] rd_mux;
  logic              is_read;

  msgbox_decode #(.ADDR_W(ADDR_W)) u_decode (
    .req_en   (bus_en),
    .req_we   (bus_we),
    .req_addr (bus_addr),
    .req_bit0 (bus_wdata[0]),
    .op       (op)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                 stage_q <= '0;
    else if (op == OP_STAGE_LO) stage_q <= bus_wdata;
  end

  assign push_msg = '{hi: bus_wdata, lo: stage_q};

  msgbox_queue #(.DEPTH(DEPTH), .WIDTH(MSG_W)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (op == OP_PUSH_HI),
    .push_data (push_msg),
    .pop       (op == OP_POP_HI),
    .head      (head_msg),
    .count     (fill),
    .is_full   (q_full),
    .is_empty  (q_empty)
  );

  // a push that lands in the last free slot, or is refused, marks the flag
  assign sticky_set = (op == OP_PUSH_HI) && (fill >= CNT_W'(DEPTH - 1));

  msgbox_sticky u_sticky (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (sticky_set),
    .clear_i (op == OP_CLEAR_STICKY),
    .flag_o  (sticky_q)
  );

  always_comb begin
    rd_mux = '0;
    case (op)
      OP_PEEK_LO:     rd_mux = q_empty ? '0 : head_msg.lo;
      OP_POP_HI:      rd_mux = q_empty ? '0 : head_msg.hi;
      OP_READ_STATUS: rd_mux = {{(WORD_W-1){1'b0}}, sticky_q};
      default:        rd_mux = '0;
    endcase
  end

  assign is_read = bus_en && !bus_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= is_read;
      bus_rdata  <= is_read ? rd_mux : '0;
    end
  end

  assign irq_not_empty = !q_empty;
  assign mbox_full     = q_full;

endmodule

// File: rtl/msgbox_checker.sv
module msgbox_checker
  import msgbox_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rvalid,
  input logic [31:0]       bus_rdata,
  input logic              irq_not_empty,
  input logic              mbox_full
);

  logic rd_req, at_lo, at_hi;
  assign rd_req = bus_en && !bus_we;
  assign at_lo  = (bus_addr == ADDR_W'(OFS_MSG_LO));
  assign at_hi  = (bus_addr == ADDR_W'(OFS_MSG_HI));

  AST_FULL_IMPLIES_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    mbox_full |-> irq_not_empty); // R7

  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> bus_rvalid); // R12

  AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !bus_rvalid); // R12

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && (at_lo || at_hi) && !irq_not_empty) |=> (bus_rdata == '0)); // R3

  AST_EMPTY_POP_STAYS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && at_hi && !irq_not_empty) |=> !irq_not_empty); // R4

  AST_STAGE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && at_lo) |=> ($stable(irq_not_empty) && $stable(mbox_full))); // R1

  AST_PUSH_SETS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && at_hi) |=> irq_not_empty); // R2

  AST_DROP_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && at_hi && mbox_full) |=> mbox_full); // R8

endmodule

bind msgbox64 msgbox_checker #(.ADDR_W(ADDR_W)) u_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_en        (bus_en),
  .bus_we        (bus_we),
  .bus_addr      (bus_addr),
  .bus_rvalid    (bus_rvalid),
  .bus_rdata     (bus_rdata),
  .irq_not_empty (irq_not_empty),
  .mbox_full     (mbox_full)
);

// File: tb/msgbox64_bench.sv
`timescale 1ns/1ps
module msgbox64_bench;

  localparam int unsigned DEPTH  = 4;
  localparam int unsigned ADDR_W = 8;
  localparam logic [7:0] A_ST = 8'h20;
  localparam logic [7:0] A_LO = 8'h24;
  localparam logic [7:0] A_HI = 8'h28;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_en = 1'b0;
  logic              bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic              bus_rvalid;
  logic [31:0]       bus_rdata;
  logic              irq_not_empty;
  logic              mbox_full;

  always #4 clk = ~clk;

  msgbox64 #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_msgbox64 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .irq_not_empty(irq_not_empty), .mbox_full(mbox_full)
  );

  int unsigned n_checks = 0;
  int unsigned n_fails  = 0;
  bit          done     = 0;

  // reference model
  logic [63:0] mq[$];
  logic [31:0] m_stage = '0;
  logic        m_sticky = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    if (a == A_ST) return {31'b0, m_sticky};
    if (a == A_LO) return (mq.size() > 0) ? mq[0][31:0] : 32'h0;
    if (a == A_HI) return (mq.size() > 0) ? mq[0][63:32] : 32'h0;
    return 32'h0;
  endfunction

  function automatic string req_of(input logic [7:0] a);
    if (a == A_ST) return "R9";
    if (a == A_LO) return "R3";
    if (a == A_HI) return "R4";
    return "R12";
  endfunction

  task automatic check_flags();
    chk("R6", {31'b0, irq_not_empty}, {31'b0, mq.size() > 0});
    chk("R7", {31'b0, mbox_full}, {31'b0, mq.size() == DEPTH});
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
    if (a == A_LO) m_stage = d;
    else if (a == A_HI) begin
      if (mq.size() >= DEPTH - 1) m_sticky = 1'b1;
      if (mq.size() < DEPTH) mq.push_back({d, m_stage});
    end else if (a == A_ST && d[0]) m_sticky = 1'b0;
    chk("R12", {31'b0, bus_rvalid}, 32'h0);
    check_flags();
  endtask

  task automatic do_read(input logic [7:0] a);
    logic [31:0] e;
    e = exp_read(a);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    chk("R12", {31'b0, bus_rvalid}, 32'h1);
    chk(req_of(a), bus_rdata, e);
    if (a == A_HI && mq.size() > 0) void'(mq.pop_front());
    check_flags();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    chk("R11", {30'b0, irq_not_empty, mbox_full}, 32'h0);
    do_read(A_ST);
    do_read(A_LO);
    do_read(A_HI); // R4 empty pop
    // R1 stage only, R2 push
    do_write(A_LO, 32'h1111_0001);
    do_write(A_HI, 32'hAAAA_0001);
    do_read(A_LO); // R3 peek twice, no pop
    do_read(A_LO);
    // R5, R7, R8, R9: fill past capacity
    for (int i = 2; i <= DEPTH + 2; i++) begin
      do_write(A_LO, 32'h1111_0000 + i);
      do_write(A_HI, 32'hAAAA_0000 + i);
    end
    do_read(A_ST);               // R9 sticky set
    do_write(A_ST, 32'hFFFF_FFFE); // R10 bit0 clear: no effect
    do_read(A_ST);
    do_write(8'h3C, 32'hDEAD_BEEF); // R12 unmapped write ignored
    do_read(8'h00);                 // R12 unmapped read zero
    for (int i = 0; i < DEPTH; i++) begin // R5 order
      do_read(A_LO);
      do_read(A_HI);
    end
    do_write(A_ST, 32'h1); // R10 clear
    do_read(A_ST);
    // random mix
    for (int n = 0; n < 1500; n++) begin
      int unsigned r;
      r = $urandom % 10;
      case (r)
        0, 1:    do_write(A_LO, $urandom);
        2, 3, 4: do_write(A_HI, $urandom);
        5:       do_read(A_LO);
        6, 7:    do_read(A_HI);
        8:       do_read(A_ST);
        default: begin
          if ($urandom % 2) do_write(A_ST, $urandom);
          else do_read(8'($urandom % 64) << 2);
        end
      endcase
    end
    summary();
  end

endmodule